// File: doc/BRIEF.md
# Regulator Start-up and Voltage Ramp Sequencer

This block sequences the power-up of a dual-output regulator controller and then tracks voltage commands. It stays idle until a supply-ready flag and an enable input are both high. On acceptance it captures a 2-bit boot selection from two pins that will later carry serial traffic. It then runs a programming delay, a parameter in clock cycles that stands for the nominal 8 ms window. The step-rate selection is sampled in the last cycle of that window.

After the delay, the DAC code climbs from zero to the boot level one LSB at a time, at the selected rate, and power-good is raised once the code has arrived. When the host raises its power-ok input, the block accepts new target codes from a parallel command port. It ramps toward each new target at the same rate. While it ramps upward it raises an on-the-fly flag. Dropping enable or the supply-ready flag at any moment sends it back to idle.

Top module: `vr_startup_seq`

## Requirements
- R1: While `por_ok` and `enable` are not both high, the sequence does not start: `dac_code` stays 0 and `power_good` stays low.
- R2: The first posedge that sees both inputs high starts a delay of `DELAY_CYC` cycles, during which `dac_code` is 0. Counting that posedge as the first, `dac_code` becomes 1 after posedge number `DELAY_CYC + I + 1`, where I is the selected step interval.
- R3: The boot selection {`svc_pin`,`svd_pin`} (svc is the MSB) is latched on the accepting posedge, and the boot target is `BOOT_BASE + BOOT_STEP*selection`. Pin changes after that posedge have no effect on the target.
- R4: Each change of `dac_code` while running is exactly one LSB toward the current target.
- R5: The step interval is `SLEW_CYC[slew_sel]` cycles per LSB. `slew_sel` is sampled on the last delay cycle, and the same interval applies to soft-start and to commanded changes.
- R6: `power_good` rises on the posedge after `dac_code` first equals the boot target, and never before.
- R7: Commands on `cmd_valid`/`cmd_code` are ignored unless `pwr_ok` is high and power-good has been reached.
- R8: An accepted command above the present `dac_code` raises `votf` on the accepting posedge. `votf` falls on the posedge after `dac_code` reaches the command.
- R9: An accepted command at or below the present `dac_code` never raises `votf`.
- R10: A low `enable` or `por_ok` on any posedge sets `dac_code` to 0 and drops `power_good` and `votf` on that same posedge, and the sequence restarts from idle.
- R11: After reset, `dac_code` is 0 and `power_good` and `votf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_ok | input | 1 | Supply above power-on-reset threshold |
| enable | input | 1 | Regulator enable |
| svc_pin | input | 1 | Serial clock pin, boot selection MSB |
| svd_pin | input | 1 | Serial data pin, boot selection LSB |
| slew_sel | input | 2 | Step interval selection |
| pwr_ok | input | 1 | Host power-ok, opens the command port |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | DAC_W | Commanded target code |
| dac_code | output | DAC_W | Present DAC code |
| power_good | output | 1 | Soft-start complete |
| votf | output | 1 | Upward on-the-fly transition in progress |

## Verification
The hardest case to reach is the boot-lock corner. It needs pins that change after acceptance but before the ramp, and then a ramp whose end value shows which pin state was used. Each boot scenario flips both pins a few cycles into the delay and checks the level at which power-good rises. The exact start cycle and the per-step interval are measured by counting posedges from the accepting edge, using a short delay parameter. A second scenario holds enable high while the supply flag is low, which covers the ordering between the two inputs.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PROG = 2'd1,
      ST_SOFT = 2'd2,
      ST_RUN  = 2'd3
   } seq_state_t;

   function automatic int unsigned boot_level(input int unsigned base,
                                              input int unsigned step,
                                              input logic [1:0]  sel);
      return base + step * int'(sel);
   endfunction

endpackage

// File: rtl/vrseq_delay.sv
module vrseq_delay #(
   parameter int unsigned CYC = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("vrseq_delay: CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign done = run && (cnt == CW'(CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt <= '0;
      end else if (run && !done) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2: the count never passes the programmed window
   p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < CW'(CYC)));

endmodule

// File: rtl/vrseq_ramp.sv
module vrseq_ramp #(
   parameter int unsigned DAC_W       = 8,
   parameter int unsigned SLEW_CYC [4] = '{4, 8, 16, 32}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             active,
   input  logic [1:0]       rate_sel,
   input  logic [DAC_W-1:0] target,
   output logic [DAC_W-1:0] dac,
   output logic             at_target
);
   localparam int unsigned M01  = (SLEW_CYC[0] > SLEW_CYC[1]) ? SLEW_CYC[0] : SLEW_CYC[1];
   localparam int unsigned M23  = (SLEW_CYC[2] > SLEW_CYC[3]) ? SLEW_CYC[2] : SLEW_CYC[3];
   localparam int unsigned MAXI = (M01 > M23) ? M01 : M23;
   localparam int unsigned IW   = $clog2(MAXI + 1);

   generate
      for (genvar i = 0; i < 4; i++) begin : g_rate_chk
         if (SLEW_CYC[i] < 1) begin : g_bad_rate
            $error("vrseq_ramp: every step interval must be at least 1");
         end
      end
   endgenerate

   logic [IW-1:0] tick;
   logic [IW-1:0] limit;

   assign limit     = IW'(SLEW_CYC[rate_sel] - 1);
   assign at_target = (dac == target);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         dac  <= '0;
         tick <= '0;
      end else if (active && !at_target) begin
         if (tick == limit) begin
            tick <= '0;
            dac  <= (target > dac) ? dac + 1'b1 : dac - 1'b1;
         end else begin
            tick <= tick + 1'b1;
         end
      end else begin
         tick <= '0;
      end
   end

   // R4: a running code moves at most one LSB per cycle
   p_one_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && $past(!clear)) |->
         (dac == $past(dac) || dac == $past(dac) + 1'b1 || dac == $past(dac) - 1'b1));

endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq #(
   parameter int unsigned DAC_W        = 8,
   parameter int unsigned DELAY_CYC    = 2000000,
   parameter int unsigned SLEW_CYC [4] = '{4, 8, 16, 32},
   parameter int unsigned BOOT_BASE    = 16,
   parameter int unsigned BOOT_STEP    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_ok,
   input  logic             enable,
   input  logic             svc_pin,
   input  logic             svd_pin,
   input  logic [1:0]       slew_sel,
   input  logic             pwr_ok,
   input  logic             cmd_valid,
   input  logic [DAC_W-1:0] cmd_code,
   output logic [DAC_W-1:0] dac_code,
   output logic             power_good,
   output logic             votf
);
   import vrseq_pkg::*;

   localparam int unsigned BOOT_MAX = BOOT_BASE + 3 * BOOT_STEP;

   generate
      if (BOOT_MAX >= (1 << DAC_W)) begin : g_bad_boot
         $error("vr_startup_seq: boot levels exceed the DAC range");
      end
      if (BOOT_BASE == 0) begin : g_bad_base
         $error("vr_startup_seq: boot level zero would skip soft-start");
      end
   endgenerate

   seq_state_t       state;
   logic [1:0]       boot_sel;
   logic [1:0]       rate_q;
   logic [DAC_W-1:0] target_q;
   logic             accept;
   logic             delay_done;
   logic             at_target;
   logic             ramp_clear;

   assign accept     = por_ok && enable;
   assign ramp_clear = !accept || (state == ST_IDLE);

   vrseq_delay #(.CYC(DELAY_CYC)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state != ST_PROG),
      .run   (state == ST_PROG),
      .done  (delay_done)
   );

   vrseq_ramp #(.DAC_W(DAC_W), .SLEW_CYC(SLEW_CYC)) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (ramp_clear),
      .active    ((state == ST_SOFT) || (state == ST_RUN)),
      .rate_sel  (rate_q),
      .target    (target_q),
      .dac       (dac_code),
      .at_target (at_target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         boot_sel   <= '0;
         rate_q     <= '0;
         target_q   <= '0;
         power_good <= 1'b0;
         votf       <= 1'b0;
      end else if (!accept) begin
         state      <= ST_IDLE;
         target_q   <= '0;
         power_good <= 1'b0;
         votf       <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               boot_sel <= {svc_pin, svd_pin};
               state    <= ST_PROG;
            end
            ST_PROG: begin
               if (delay_done) begin
                  rate_q   <= slew_sel;
                  target_q <= DAC_W'(boot_level(BOOT_BASE, BOOT_STEP, boot_sel));
                  state    <= ST_SOFT;
               end
            end
            ST_SOFT: begin
               if (at_target) begin
                  power_good <= 1'b1;
                  state      <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (pwr_ok && cmd_valid) begin
                  target_q <= cmd_code;
                  votf     <= (cmd_code > dac_code);
               end else if (at_target) begin
                  votf <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: no ramp activity during the programming window
   p_quiet_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROG) |-> (dac_code == '0));

   // R6: power-good rises only with the code at its target
   p_pg_at_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(power_good) |-> (dac_code == target_q && state == ST_RUN));

   // R7: targets hold while the host has not granted commands
   p_cmd_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && accept && !pwr_ok) |=> $stable(target_q));

   // R8 / R9: the flag rises only for an accepted increase
   p_votf_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(votf) |-> ($past(cmd_code) > $past(dac_code) && $past(pwr_ok) && $past(cmd_valid)));

   // R10: losing enable or supply clears the outputs
   p_drop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> (dac_code == '0 && !power_good && !votf));

endmodule

// File: tb/tb_vr_startup_seq.sv
`timescale 1ns/1ps
module tb_vr_startup_seq;
   localparam int unsigned DAC_W = 8;
   localparam int unsigned D     = 40;
   localparam int unsigned BASE  = 16;
   localparam int unsigned STEP  = 8;
   localparam int unsigned RATE [4] = '{2, 3, 5, 7};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por_ok = 1'b0, enable = 1'b0, svc_pin = 1'b0, svd_pin = 1'b0;
   logic [1:0] slew_sel = 2'd0;
   logic pwr_ok = 1'b0, cmd_valid = 1'b0;
   logic [DAC_W-1:0] cmd_code = '0;
   logic [DAC_W-1:0] dac_code;
   logic power_good, votf;

   int checks = 0;
   int bad = 0;

   always #2 clk = ~clk;

   vr_startup_seq #(.DAC_W(DAC_W), .DELAY_CYC(D), .SLEW_CYC(RATE),
                    .BOOT_BASE(BASE), .BOOT_STEP(STEP)) dut (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .enable(enable),
      .svc_pin(svc_pin), .svd_pin(svd_pin), .slew_sel(slew_sel),
      .pwr_ok(pwr_ok), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .dac_code(dac_code), .power_good(power_good), .votf(votf));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step1();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_reset();
      chk(dac_code == 0, "R11 dac", dac_code, 0);
      chk(power_good == 0, "R11 pg", power_good, 0);
      chk(votf == 0, "R11 votf", votf, 0);
   endtask

   task automatic t_gate();
      enable = 1'b1; por_ok = 1'b0;
      for (int i = 0; i < 20; i++) begin
         step1();
         if (dac_code != 0 || power_good) chk(1'b0, "R1 held", dac_code, 0);
      end
      chk(dac_code == 0 && !power_good, "R1 idle", dac_code, 0);
      enable = 1'b0; step1();
   endtask

   // full start-up; pins flipped during the delay
   task automatic t_boot(input logic [1:0] code, input logic [1:0] sel, input bit por_last);
      int n, m;
      int tgt;
      tgt = BASE + STEP * code;
      {svc_pin, svd_pin} = code;
      slew_sel = sel;
      pwr_ok = 1'b0;
      if (por_last) begin enable = 1'b1; por_ok = 1'b1; end
      else begin por_ok = 1'b1; enable = 1'b1; end
      n = 0;
      for (int i = 0; i < D + 100; i++) begin
         @(posedge clk); n++;
         if (n == 3) {svc_pin, svd_pin} = ~code;
         @(negedge clk);
         if (dac_code != 0) break;
      end
      chk(n == D + RATE[sel] + 1, "R2 start edge", n, D + RATE[sel] + 1);
      chk(dac_code == 1, "R4 first step", dac_code, 1);
      m = 0;
      for (int i = 0; i < 50; i++) begin
         @(posedge clk); m++; @(negedge clk);
         if (dac_code != 1) break;
      end
      chk(m == RATE[sel], "R5 interval", m, RATE[sel]);
      chk(dac_code == 2, "R4 second step", dac_code, 2);
      for (int i = 0; i < 2000; i++) begin
         if (dac_code == tgt) break;
         if (power_good) chk(1'b0, "R6 early pg", dac_code, tgt);
         step1();
      end
      chk(dac_code == tgt, "R3 boot level", dac_code, tgt);
      chk(power_good == 0, "R6 pg not yet", power_good, 0);
      step1();
      chk(power_good == 1, "R6 pg rise", power_good, 1);
   endtask

   task automatic t_cmd_blocked();
      int held;
      held = dac_code;
      pwr_ok = 1'b0; cmd_valid = 1'b1; cmd_code = 8'd100;
      for (int i = 0; i < 15; i++) step1();
      cmd_valid = 1'b0;
      chk(dac_code == held, "R7 ignored", dac_code, held);
      chk(votf == 0, "R7 no votf", votf, 0);
   endtask

   task automatic t_up(input logic [DAC_W-1:0] code);
      pwr_ok = 1'b1; cmd_valid = 1'b1; cmd_code = code;
      step1();
      cmd_valid = 1'b0;
      chk(votf == 1, "R8 votf set", votf, 1);
      for (int i = 0; i < 2000; i++) begin
         if (dac_code == code) break;
         step1();
      end
      chk(dac_code == code, "R8 reached", dac_code, code);
      chk(votf == 1, "R8 votf held", votf, 1);
      step1();
      chk(votf == 0, "R8 votf clear", votf, 0);
      chk(power_good == 1, "R8 pg kept", power_good, 1);
   endtask

   task automatic t_down(input logic [DAC_W-1:0] code);
      bit seen;
      seen = 1'b0;
      pwr_ok = 1'b1; cmd_valid = 1'b1; cmd_code = code;
      step1();
      cmd_valid = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         if (votf) seen = 1'b1;
         if (dac_code == code) break;
         step1();
      end
      chk(dac_code == code, "R9 reached", dac_code, code);
      chk(!seen, "R9 no votf", seen, 0);
   endtask

   task automatic t_drop(input bit use_por);
      if (use_por) por_ok = 1'b0; else enable = 1'b0;
      step1();
      chk(dac_code == 0, "R10 dac", dac_code, 0);
      chk(power_good == 0 && votf == 0, "R10 flags", power_good + votf, 0);
      for (int i = 0; i < 5; i++) step1();
      chk(dac_code == 0, "R10 stays idle", dac_code, 0);
      por_ok = 1'b0; enable = 1'b0; pwr_ok = 1'b0;
      step1();
   endtask

   initial begin
      #800000;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step1();
      t_reset();
      t_gate();
      t_boot(2'd0, 2'd0, 1'b1);
      t_cmd_blocked();
      t_up(8'd40);
      t_down(8'd10);
      t_drop(1'b0);
      t_boot(2'd3, 2'd3, 1'b0);
      t_up(8'd60);
      t_drop(1'b1);
      t_boot(2'd1, 2'd2, 1'b0);
      pwr_ok = 1'b1; cmd_valid = 1'b1; cmd_code = 8'd90;
      step1();
      cmd_valid = 1'b0;
      for (int i = 0; i < 4; i++) step1();
      t_drop(1'b0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule